// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block carries out the entry into a real-mode interrupt handler on behalf of a processor core. A raise request carrying an 8-bit vector number is latched as pending. When the core next reports an instruction boundary, the sequencer either grants the fetch or, if the pending vector may be taken, takes over a 16-bit memory port. It saves the old flags word, code segment and instruction pointer on the stack and fetches the handler's segment and offset from a table of 4-byte entries starting at physical address zero.

Once the last table word arrives, the sequencer pulses a completion strobe and presents the new flags word (interrupt-enable and trap cleared), the new code segment, the new instruction pointer and the stack pointer lowered by six. The core loads these values and resumes fetching at the handler. A sticky halt input stops the block from granting fetches or starting any new sequence until reset.

Top module: `irq_entry_seq`

## Requirements
- R1: A raise request (raise_valid high at a clock edge) stores raise_vec and marks it pending; a later request overwrites the stored vector. When boundary_i is high, the block is idle, not halted and the pending vector is eligible, the sequence starts at that edge and fetch_ok is low in that cycle; otherwise fetch_ok equals boundary_i while idle and not halted.
- R2: The three pushes are issued in the order flags, code segment, instruction pointer. They write flags_i, cs_i and ip_i as sampled at the start edge to physical addresses (ss*16 + sp-2), (ss*16 + sp-4) and (ss*16 + sp-6). The stack offset wraps at 16 bits and the physical address wraps at 20 bits.
- R3: The new code segment is read from address vector*4+2, directly after the code-segment push. The new instruction pointer is read from address vector*4, directly after the instruction-pointer push. Both appear on new_cs and new_ip when done is high.
- R4: When done is high, new_flags equals the sampled flags with bit 9 (interrupt enable) and bit 8 (trap) cleared, and new_sp equals the sampled SP minus 6, modulo 2^16.
- R5: Each word access holds mem_req high with stable mem_we, mem_addr and mem_wdata until a cycle with mem_ack high. That cycle completes the access; mem_ack may already be high in the first cycle of the request.
- R6: busy is high from the cycle after the start edge up to and including the cycle of the final acknowledge. done is high for exactly the following cycle, with busy low. mem_req is never high unless busy is high.
- R7: Completion clears the pending state, so the next boundary is granted a fetch without another sequence.
- R8: A high halt_i at a clock edge sets a halted flag that only reset clears. While it is set, stopped is high, fetch_ok is low and no new sequence starts, even for a pending vector 0.
- R9: Vectors 0 and 2 are taken whatever flags_i bit 9 is. Any other vector is taken only while flags_i bit 9 is high; otherwise the fetch is granted and the vector stays pending.
- R10: A raise request in the start cycle or while busy is dropped and does not become pending.
- R11: After reset nothing is pending, stopped, busy, done and mem_req are low, and a boundary is granted a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_valid | input | 1 | Interrupt raise request |
| raise_vec | input | 8 | Vector number of the request |
| halt_i | input | 1 | Sets the sticky halted flag |
| boundary_i | input | 1 | Core is at an instruction boundary and asks to fetch |
| fetch_ok | output | 1 | Fetch granted at this boundary |
| stopped | output | 1 | Halted flag |
| flags_i | input | 16 | Core flags word |
| cs_i | input | 16 | Core code segment |
| ip_i | input | 16 | Core instruction pointer |
| sp_i | input | 16 | Core stack pointer |
| ss_i | input | 16 | Core stack segment |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| new_flags | output | 16 | Flags to load on completion |
| new_cs | output | 16 | Code segment to load on completion |
| new_ip | output | 16 | Instruction pointer to load on completion |
| new_sp | output | 16 | Stack pointer to load on completion |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access acknowledge |

## Verification
The hardest situation to reach is a request that arrives while a sequence is running, because from the ports it looks like an ordinary raise. The bench pulses a second raise during the first stack push of a sequence and then offers a boundary with interrupts enabled. It checks that the fetch is granted and that no memory request follows. Wrap-around of the stack offset and of the 20-bit physical address is reached by sweeping all 256 vectors with SP and SS values derived from the vector, including SP=0 and SS=0xFFFF. The acknowledge delay varies from 0 to 2 cycles across the sweep.

// File: rtl/irq_seq_pkg.sv
// Package: shared state encoding for the interrupt entry sequencer.
// Assumes: states are decoded only inside this block.
package irq_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_PSH_FL = 3'd1,
        S_PSH_CS = 3'd2,
        S_LD_CS  = 3'd3,
        S_PSH_IP = 3'd4,
        S_LD_IP  = 3'd5,
        S_DONE   = 3'd6
    } seq_st_t;
endpackage

// File: rtl/irq_pend_latch.sv
// Module: holds the pending flag and the vector number of the last accepted
// raise request. Assumes the caller removes accept_en while a sequence runs.
module irq_pend_latch #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise_valid,
    input  logic [VEC_W-1:0] raise_vec,
    input  logic             accept_en,
    input  logic             clear,
    output logic             pend,
    output logic [VEC_W-1:0] vec
);
    // Record or drop a pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            vec  <= '0;
        end else if (clear) begin
            pend <= 1'b0;
        end else if (accept_en && raise_valid) begin
            pend <= 1'b1;
            vec  <= raise_vec;
        end
    end
endmodule

// File: rtl/irq_seq_fsm.sv
// Module: steps through the five memory accesses of the entry sequence,
// one per acknowledge. Assumes start is only asserted in S_IDLE.
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    mem_ack,
    output seq_st_t state
);
    seq_st_t nxt;

    // Next-state choice.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:   if (start)   nxt = S_PSH_FL;
            S_PSH_FL: if (mem_ack) nxt = S_PSH_CS;
            S_PSH_CS: if (mem_ack) nxt = S_LD_CS;
            S_LD_CS:  if (mem_ack) nxt = S_PSH_IP;
            S_PSH_IP: if (mem_ack) nxt = S_LD_IP;
            S_LD_IP:  if (mem_ack) nxt = S_DONE;
            S_DONE:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/irq_addr_gen.sv
// Module: forms the request, direction, physical address and write data of
// the current access. Stack pushes use segment*16 + offset with the offset
// lowered by 2, 4 or 6; table reads use vector*4 (+2). Purely combinational.
module irq_addr_gen
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int VEC_W     = 8,
    parameter int SEG_SHIFT = 4
) (
    input  seq_st_t           state,
    input  logic [DATA_W-1:0] ss,
    input  logic [DATA_W-1:0] sp,
    input  logic [VEC_W-1:0]  vec,
    input  logic [DATA_W-1:0] flags,
    input  logic [DATA_W-1:0] cs,
    input  logic [DATA_W-1:0] ip,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    localparam int ENTRY_SHIFT = 2;

    logic [ADDR_W-1:0] seg_base;
    logic [ADDR_W-1:0] tbl_base;
    logic [DATA_W-1:0] off;

    assign seg_base = ADDR_W'(ss) << SEG_SHIFT;
    assign tbl_base = ADDR_W'(vec) << ENTRY_SHIFT;

    // Select the stack offset for each push.
    always_comb begin
        case (state)
            S_PSH_FL: off = sp - DATA_W'(2);
            S_PSH_CS: off = sp - DATA_W'(4);
            default:  off = sp - DATA_W'(6);
        endcase
    end

    // Decode the access for the current state.
    always_comb begin
        req   = 1'b1;
        we    = 1'b1;
        addr  = seg_base + ADDR_W'(off);
        wdata = '0;
        case (state)
            S_PSH_FL: wdata = flags;
            S_PSH_CS: wdata = cs;
            S_PSH_IP: wdata = ip;
            S_LD_CS: begin
                we   = 1'b0;
                addr = tbl_base + ADDR_W'(2);
            end
            S_LD_IP: begin
                we   = 1'b0;
                addr = tbl_base;
            end
            default: begin
                req  = 1'b0;
                we   = 1'b0;
                addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Module: top of the interrupt entry sequencer. Latches raise requests, at an
// instruction boundary either grants the fetch or runs the push/load sequence,
// and presents the new core context with a one-cycle done strobe.
// Assumes: the core holds flags_i/cs_i/ip_i/sp_i/ss_i valid with boundary_i
// and loads new_* when done is high.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int VEC_W     = 8,
    parameter int SEG_SHIFT = 4,
    parameter int IF_BIT    = 9,
    parameter int TF_BIT    = 8,
    parameter int NMI_VEC_A = 0,
    parameter int NMI_VEC_B = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_valid,
    input  logic [VEC_W-1:0]  raise_vec,
    input  logic              halt_i,
    input  logic              boundary_i,
    output logic              fetch_ok,
    output logic              stopped,
    input  logic [DATA_W-1:0] flags_i,
    input  logic [DATA_W-1:0] cs_i,
    input  logic [DATA_W-1:0] ip_i,
    input  logic [DATA_W-1:0] sp_i,
    input  logic [DATA_W-1:0] ss_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] new_flags,
    output logic [DATA_W-1:0] new_cs,
    output logic [DATA_W-1:0] new_ip,
    output logic [DATA_W-1:0] new_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam logic [DATA_W-1:0] CLR_MASK =
        ~((DATA_W'(1) << IF_BIT) | (DATA_W'(1) << TF_BIT));
    localparam logic [DATA_W-1:0] FRAME_BYTES = DATA_W'(6);

    seq_st_t           state;
    logic              pend;
    logic [VEC_W-1:0]  pvec;
    logic              halted;
    logic              eligible;
    logic              idle_free;
    logic              start;
    logic              seq_end;
    logic [DATA_W-1:0] c_flags, c_cs, c_ip, c_sp, c_ss;

    assign idle_free = (state == S_IDLE) && !halted;
    assign eligible  = pend && ((pvec == VEC_W'(NMI_VEC_A)) ||
                                (pvec == VEC_W'(NMI_VEC_B)) ||
                                flags_i[IF_BIT]);
    assign start     = boundary_i && idle_free && eligible;
    assign fetch_ok  = boundary_i && idle_free && !eligible;
    assign seq_end   = (state == S_LD_IP) && mem_ack;
    assign busy      = (state != S_IDLE) && (state != S_DONE);
    assign done      = (state == S_DONE);
    assign stopped   = halted;

    irq_pend_latch #(.VEC_W(VEC_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_valid(raise_valid),
        .raise_vec  (raise_vec),
        .accept_en  (!busy && !start),
        .clear      (seq_end),
        .pend       (pend),
        .vec        (pvec)
    );

    irq_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mem_ack(mem_ack),
        .state  (state)
    );

    irq_addr_gen #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .VEC_W    (VEC_W),
        .SEG_SHIFT(SEG_SHIFT)
    ) u_agen (
        .state(state),
        .ss   (c_ss),
        .sp   (c_sp),
        .vec  (pvec),
        .flags(c_flags),
        .cs   (c_cs),
        .ip   (c_ip),
        .req  (mem_req),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata(mem_wdata)
    );

    // Sticky halted flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      halted <= 1'b0;
        else if (halt_i) halted <= 1'b1;
    end

    // Capture the core context and the derived flags/SP at the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_flags   <= '0;
            c_cs      <= '0;
            c_ip      <= '0;
            c_sp      <= '0;
            c_ss      <= '0;
            new_flags <= '0;
            new_sp    <= '0;
        end else if (start) begin
            c_flags   <= flags_i;
            c_cs      <= cs_i;
            c_ip      <= ip_i;
            c_sp      <= sp_i;
            c_ss      <= ss_i;
            new_flags <= flags_i & CLR_MASK;
            new_sp    <= sp_i - FRAME_BYTES;
        end
    end

    // Load the handler segment and offset from the vector table reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_cs <= '0;
            new_ip <= '0;
        end else if (mem_ack && state == S_LD_CS) begin
            new_cs <= mem_rdata;
        end else if (mem_ack && state == S_LD_IP) begin
            new_ip <= mem_rdata;
        end
    end
endmodule

// File: rtl/irq_entry_seq_chk.sv
// Module: property checker for irq_entry_seq, attached with bind below.
// Assumes: only observes ports of the top module.
module irq_entry_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fetch_ok,
    input logic              stopped,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy) && $past(mem_ack)); // R6
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R6
    AST_NO_FETCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fetch_ok); // R1
    AST_HALT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !fetch_ok); // R8
    AST_HALT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && !busy |=> !busy); // R8
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .fetch_ok (fetch_ok),
    .stopped  (stopped),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/irq_entry_seq_test.sv
// Bench: sweeps all vectors through the entry sequence with a bench-side
// memory responder and computes every expected value arithmetically.
module irq_entry_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_valid = 1'b0;
    logic [7:0]  raise_vec = '0;
    logic        halt_i = 1'b0;
    logic        boundary_i = 1'b0;
    logic        fetch_ok, stopped, busy, done;
    logic [15:0] flags_i = '0, cs_i = '0, ip_i = '0, sp_i = '0, ss_i = '0;
    logic [15:0] new_flags, new_cs, new_ip, new_sp;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .raise_valid(raise_valid), .raise_vec(raise_vec),
        .halt_i(halt_i), .boundary_i(boundary_i), .fetch_ok(fetch_ok), .stopped(stopped),
        .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i), .sp_i(sp_i), .ss_i(ss_i),
        .busy(busy), .done(done), .new_flags(new_flags), .new_cs(new_cs),
        .new_ip(new_ip), .new_sp(new_sp), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [15:0] tbl_word(input logic [19:0] a);
        return a[15:0] * 16'd7 + 16'h1357;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic raise(input logic [7:0] v);
        @(negedge clk);
        raise_valid = 1'b1;
        raise_vec   = v;
        @(negedge clk);
        raise_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // One full entry sequence for pending vector v; w = acknowledge delay.
    task automatic service(input logic [7:0] v, input logic [15:0] fl,
                           input logic [15:0] cs, input logic [15:0] ip,
                           input logic [15:0] sp, input logic [15:0] ss,
                           input int w, input bit mid_raise);
        logic [19:0] ea;
        logic [15:0] ed;
        logic        ew;
        @(negedge clk);
        flags_i = fl; cs_i = cs; ip_i = ip; sp_i = sp; ss_i = ss;
        boundary_i = 1'b1;
        #1;
        chk("R1", "fetch_ok at start", {31'd0, fetch_ok}, 32'd0);
        @(negedge clk);
        boundary_i = 1'b0;
        #1;
        chk("R6", "busy after start", {31'd0, busy}, 32'd1);
        for (int k = 0; k < 5; k++) begin
            case (k)
                0: begin ew = 1'b1; ea = (20'(ss) << 4) + 20'(16'(sp - 16'd2)); ed = fl; end
                1: begin ew = 1'b1; ea = (20'(ss) << 4) + 20'(16'(sp - 16'd4)); ed = cs; end
                2: begin ew = 1'b0; ea = (20'(v) << 2) + 20'd2; ed = '0; end
                3: begin ew = 1'b1; ea = (20'(ss) << 4) + 20'(16'(sp - 16'd6)); ed = ip; end
                default: begin ew = 1'b0; ea = 20'(v) << 2; ed = '0; end
            endcase
            chk("R2", "mem_req", {31'd0, mem_req}, 32'd1);
            chk("R2", "mem_we", {31'd0, mem_we}, {31'd0, ew});
            chk(ew ? "R2" : "R3", "mem_addr", {12'd0, mem_addr}, {12'd0, ea});
            if (ew) chk("R2", "mem_wdata", {16'd0, mem_wdata}, {16'd0, ed});
            if (mid_raise && k == 0) begin
                raise_valid = 1'b1;
                raise_vec   = 8'h11;
            end
            for (int d = 0; d < w; d++) begin
                @(negedge clk);
                raise_valid = 1'b0;
                #1;
                chk("R5", "req held", {31'd0, mem_req}, 32'd1);
                chk("R5", "addr held", {12'd0, mem_addr}, {12'd0, ea});
            end
            mem_ack   = 1'b1;
            mem_rdata = ew ? 16'hDEAD : tbl_word(ea);
            @(negedge clk);
            mem_ack     = 1'b0;
            raise_valid = 1'b0;
            #1;
        end
        chk("R6", "done pulse", {31'd0, done}, 32'd1);
        chk("R6", "busy at done", {31'd0, busy}, 32'd0);
        chk("R4", "new_flags", {16'd0, new_flags}, {16'd0, fl & 16'hFCFF});
        chk("R4", "new_sp", {16'd0, new_sp}, {16'd0, 16'(sp - 16'd6)});
        chk("R3", "new_cs", {16'd0, new_cs}, {16'd0, tbl_word((20'(v) << 2) + 20'd2)});
        chk("R3", "new_ip", {16'd0, new_ip}, {16'd0, tbl_word(20'(v) << 2)});
        @(negedge clk);
        #1;
        chk("R6", "done ends", {31'd0, done}, 32'd0);
    endtask

    // Boundary that must be granted a fetch with no memory activity.
    task automatic expect_grant(input string req, input logic [15:0] fl);
        @(negedge clk);
        flags_i = fl;
        boundary_i = 1'b1;
        #1;
        chk(req, "fetch granted", {31'd0, fetch_ok}, 32'd1);
        @(negedge clk);
        boundary_i = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(req, "no access", {31'd0, mem_req}, 32'd0);
        chk(req, "not busy", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                tests++;
                $display("FAIL watchdog: actual %0d expected <150000", cyc);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] fl;
        do_reset();
        // R11: reset state
        chk("R11", "busy", {31'd0, busy}, 32'd0);
        chk("R11", "done", {31'd0, done}, 32'd0);
        chk("R11", "stopped", {31'd0, stopped}, 32'd0);
        chk("R11", "mem_req", {31'd0, mem_req}, 32'd0);
        expect_grant("R11", 16'h0200);

        // R2 R3 R4 R5: sweep every vector with IF set, wrapping SP/SS
        for (int i = 0; i < 256; i++) begin
            v  = 8'(i);
            fl = {v, ~v} | 16'h0200;
            raise(v);
            service(v, fl, 16'(i * 13), ~16'(i * 29), 16'(i * 257), ~{v, v}, i % 3, 1'b0);
        end
        // R7: pending cleared after completion
        expect_grant("R7", 16'h0200);

        // R1: a later raise overwrites the vector
        raise(8'd3);
        raise(8'd4);
        service(8'd4, 16'h0301, 16'h1000, 16'h2000, 16'h0100, 16'h0040, 1, 1'b0);

        // R9: vectors 0 and 2 taken with IF clear
        raise(8'd0);
        service(8'd0, 16'h0100, 16'hAAAA, 16'h5555, 16'h8000, 16'h1234, 0, 1'b0);
        raise(8'd2);
        service(8'd2, 16'h0000, 16'h0F0F, 16'hF0F0, 16'h0004, 16'h0001, 2, 1'b0);

        // R9: vector 5 masked while IF clear, stays pending, then taken
        raise(8'd5);
        expect_grant("R9", 16'h0000);
        expect_grant("R9", 16'h0100);
        service(8'd5, 16'h0200, 16'h0123, 16'h4567, 16'h0200, 16'h0300, 0, 1'b0);

        // R10: raise during a running sequence is dropped
        raise(8'd9);
        service(8'd9, 16'h0200, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 1, 1'b1);
        expect_grant("R10", 16'h0200);

        // R8: halt has priority over a pending vector 0
        raise(8'd0);
        @(negedge clk);
        halt_i = 1'b1;
        @(negedge clk);
        halt_i = 1'b0;
        boundary_i = 1'b1;
        #1;
        chk("R8", "stopped", {31'd0, stopped}, 32'd1);
        chk("R8", "no fetch", {31'd0, fetch_ok}, 32'd0);
        repeat (3) @(negedge clk);
        #1;
        chk("R8", "no start", {31'd0, busy}, 32'd0);
        chk("R8", "no access", {31'd0, mem_req}, 32'd0);
        chk("R8", "still stopped", {31'd0, stopped}, 32'd1);
        boundary_i = 1'b0;

        // R11: reset clears halt and pending
        do_reset();
        chk("R11", "stopped cleared", {31'd0, stopped}, 32'd0);
        expect_grant("R11", 16'h0000);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule